// File: doc/BRIEF.md
# Configuration Packet Stream Serializer

This block produces the 32-bit word stream that loads a programmable device's configuration. A start pulse makes it emit a fixed six-word synchronization preamble. It then emits a series of packets. For each packet it takes one descriptor on a valid/ready handshake. The descriptor gives the packet type, a two-bit opcode, a register address, a length and a final-packet flag. The block builds the header word from these fields, emits it, and then forwards the payload words from a second valid/ready input. The output is a valid/ready stream with a last flag.

Every packet passes through three phases: header, data and end. The data phase is skipped when the payload count taken from the header is zero. The end phase lasts one idle cycle. After it, the block accepts the next descriptor, or goes idle if the packet just finished was marked final. If a start is given with the no-packet flag set, the stream is the preamble alone.

Top module: `cfg_stream_packer`

## Requirements
- R1: After a start pulse in the idle state, the first six output words are 0xFFFFFFFF, 0x000000BB, 0x11220044, 0xFFFFFFFF, 0xFFFFFFFF, 0xAA995566, in that order.
- R2: The first output word of every packet is its header, and header bits [31:29] equal the descriptor type.
- R3: For type 1, the header holds the opcode in [28:27], the address in [26:13], zeros in [12:11] and the length's low 11 bits in [10:0]. That 11-bit value is the payload word count.
- R4: For type 2, the header holds the opcode in [28:27] and the 27-bit length in [26:0]. No address bits appear, and the 27-bit value is the payload word count.
- R5: For type 0 and types 3 to 7, only bits [31:29] are set (to the type), all other header bits are zero, and no payload word follows.
- R6: When the payload count is zero, the header is followed directly by the end phase and the next descriptor. No payload word is taken.
- R7: In the data phase, each payload input word is passed to the output unchanged, one per handshake, and exactly the counted number of words is taken.
- R8: While a preamble or header word is offered with out_ready low, out_valid stays high and out_data stays unchanged. The stream advances only on a handshake.
- R9: out_last is high on the final word of the packet flagged final: its last payload word, or its header when the count is zero. After that packet the block goes idle and accepts no descriptor.
- R10: A start with start_nopkt high emits only the six preamble words, with out_last on the sixth, and then goes idle.
- R11: After reset, out_valid, desc_ready and pay_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a stream when idle |
| start_nopkt | input | 1 | With start: stream carries the preamble only |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_type | input | 3 | Packet type |
| desc_op | input | 2 | Opcode |
| desc_addr | input | 14 | Register address (type 1 only) |
| desc_len | input | 27 | Payload length |
| desc_final | input | 1 | This packet ends the stream |
| pay_valid | input | 1 | Payload word offered |
| pay_ready | output | 1 | Payload word taken |
| pay_data | input | 32 | Payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Final word of the stream |

## Verification
The bench aims at type 1 lengths with bits set above bit 10. A design that leaked those bits would corrupt header bits [12:11] and take the wrong number of payload words. It also sends zero-length and padding-type packets, where a wrong design would wait for payload that never comes or misplace out_last. Stalls on preamble and header words would reveal a design that skips or changes a word under backpressure. Preamble-only and zero-length final packets would show out_last on the wrong word or a block that fails to go idle.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int WORD_W  = 32;
  localparam int TYPE_W  = 3;
  localparam int OP_W    = 2;
  localparam int ADDR_W  = 14;
  localparam int LEN_W   = 27;
  localparam int SHORT_W = 11;
  localparam int PRE_N   = 6;
  localparam int PIDX_W  = $clog2(PRE_N + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_WAIT, PH_HDR, PH_DATA, PH_END
  } phase_e;

  typedef struct packed {
    logic [TYPE_W-1:0] kind;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              last_pkt;
  } desc_t;

  function automatic logic [WORD_W-1:0] sync_word(input logic [PIDX_W-1:0] idx);
    case (idx)
      3'd0:    sync_word = 32'hFFFF_FFFF;
      3'd1:    sync_word = 32'h0000_00BB;
      3'd2:    sync_word = 32'h1122_0044;
      3'd3:    sync_word = 32'hFFFF_FFFF;
      3'd4:    sync_word = 32'hFFFF_FFFF;
      3'd5:    sync_word = 32'hAA99_5566;
      default: sync_word = '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] make_header(
      input logic [TYPE_W-1:0] kind, input logic [OP_W-1:0] op,
      input logic [ADDR_W-1:0] addr, input logic [LEN_W-1:0] len);
    case (kind)
      3'd1:    make_header = {kind, op, addr, 2'b00, len[SHORT_W-1:0]};
      3'd2:    make_header = {kind, op, len};
      default: make_header = {kind, {(WORD_W-TYPE_W){1'b0}}};
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] words_after(
      input logic [TYPE_W-1:0] kind, input logic [LEN_W-1:0] len);
    case (kind)
      3'd1:    words_after = {{(LEN_W-SHORT_W){1'b0}}, len[SHORT_W-1:0]};
      3'd2:    words_after = len;
      default: words_after = '0;
    endcase
  endfunction
endpackage

// File: rtl/cfgsp_preamble.sv
module cfgsp_preamble
  import cfgsp_pkg::*;
#(
  parameter int IDX_W = PIDX_W,
  parameter int DW    = WORD_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    word
);
  always_comb word = sync_word(idx);
endmodule

// File: rtl/cfgsp_hdr_enc.sv
module cfgsp_hdr_enc
  import cfgsp_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int LW = LEN_W
) (
  input  logic [TYPE_W-1:0] kind,
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LW-1:0]     len,
  output logic [DW-1:0]     hdr,
  output logic [LW-1:0]     count,
  output logic              empty
);
  always_comb begin
    hdr   = make_header(kind, op, addr, len);
    count = words_after(kind, len);
    empty = (count == '0);
  end
endmodule

// File: rtl/cfgsp_seq.sv
module cfgsp_seq
  import cfgsp_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int LW = LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_nopkt,
  input  logic              desc_valid,
  input  desc_t             desc_in,
  output logic              desc_ready,
  output desc_t             desc_q,
  input  logic [DW-1:0]     hdr_word,
  input  logic [LW-1:0]     hdr_count,
  input  logic              hdr_empty,
  output logic [PIDX_W-1:0] pre_idx,
  input  logic [DW-1:0]     pre_word,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [DW-1:0]     pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  output logic              ev_out_hs,
  output logic              ev_in_payload
);
  localparam logic [PIDX_W-1:0] PRE_LAST = PIDX_W'(PRE_N - 1);

  phase_e            ph_q;
  logic [PIDX_W-1:0] idx_q;
  logic [LW-1:0]     rem_q;
  logic              nopkt_q;

  assign pre_idx = idx_q;

  always_comb begin
    desc_ready = (ph_q == PH_WAIT);
    out_valid  = 1'b0;
    out_data   = '0;
    out_last   = 1'b0;
    case (ph_q)
      PH_PRE: begin
        out_valid = 1'b1;
        out_data  = pre_word;
        out_last  = nopkt_q && (idx_q == PRE_LAST);
      end
      PH_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_word;
        out_last  = desc_q.last_pkt && hdr_empty;
      end
      PH_DATA: begin
        out_valid = pay_valid;
        out_data  = pay_data;
        out_last  = pay_valid && desc_q.last_pkt && (rem_q == LW'(1));
      end
      default: ;
    endcase
    pay_ready     = (ph_q == PH_DATA) && out_ready;
    ev_out_hs     = out_valid && out_ready;
    ev_in_payload = (ph_q == PH_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      nopkt_q <= 1'b0;
      desc_q  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q    <= PH_PRE;
          idx_q   <= '0;
          nopkt_q <= start_nopkt;
        end
        PH_PRE: if (ev_out_hs) begin
          if (idx_q == PRE_LAST) ph_q <= nopkt_q ? PH_IDLE : PH_WAIT;
          else idx_q <= idx_q + 1'b1;
        end
        PH_WAIT: if (desc_valid) begin
          desc_q <= desc_in;
          ph_q   <= PH_HDR;
        end
        PH_HDR: if (ev_out_hs) begin
          if (hdr_empty) ph_q <= PH_END;
          else begin
            rem_q <= hdr_count;
            ph_q  <= PH_DATA;
          end
        end
        PH_DATA: if (ev_out_hs) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LW'(1)) ph_q <= PH_END;
        end
        PH_END: ph_q <= desc_q.last_pkt ? PH_IDLE : PH_WAIT;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_stream_packer.sv
module cfg_stream_packer
  import cfgsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_nopkt,
  input  logic                 desc_valid,
  output logic                 desc_ready,
  input  logic [TYPE_W-1:0]    desc_type,
  input  logic [OP_W-1:0]      desc_op,
  input  logic [ADDR_W-1:0]    desc_addr,
  input  logic [LEN_W-1:0]     desc_len,
  input  logic                 desc_final,
  input  logic                 pay_valid,
  output logic                 pay_ready,
  input  logic [WORD_W-1:0]    pay_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_data,
  output logic                 out_last
);
  desc_t             desc_in, desc_q;
  logic [WORD_W-1:0] hdr_word, pre_word;
  logic [LEN_W-1:0]  hdr_count;
  logic              hdr_empty;
  logic [PIDX_W-1:0] pre_idx;
  logic              ev_out_hs, ev_in_payload;

  assign desc_in = '{kind: desc_type, op: desc_op, addr: desc_addr,
                     len: desc_len, last_pkt: desc_final};

  cfgsp_preamble u_pre (.idx(pre_idx), .word(pre_word));

  cfgsp_hdr_enc u_enc (
    .kind(desc_q.kind), .op(desc_q.op), .addr(desc_q.addr), .len(desc_q.len),
    .hdr(hdr_word), .count(hdr_count), .empty(hdr_empty)
  );

  cfgsp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_nopkt(start_nopkt),
    .desc_valid(desc_valid), .desc_in(desc_in), .desc_ready(desc_ready),
    .desc_q(desc_q), .hdr_word(hdr_word), .hdr_count(hdr_count),
    .hdr_empty(hdr_empty), .pre_idx(pre_idx), .pre_word(pre_word),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .ev_out_hs(ev_out_hs), .ev_in_payload(ev_in_payload)
  );
endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        desc_valid,
  input logic        desc_ready,
  input logic [2:0]  desc_type,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic [31:0] pay_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_last,
  input logic        ev_in_payload
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !ev_in_payload |=> out_valid && $stable(out_data)); // R8
  AST_HDR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> out_valid && out_data[31:29] == $past(desc_type)); // R2
  AST_T1_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && desc_type == 3'd1 |=> out_data[12:11] == 2'b00); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && desc_type == 3'd0 |=> out_data[28:0] == '0); // R5
  AST_PAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && pay_ready |-> out_valid && out_data == pay_data); // R7
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R9
endmodule

bind cfg_stream_packer cfgsp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_type(desc_type), .pay_valid(pay_valid), .pay_ready(pay_ready),
  .pay_data(pay_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .ev_in_payload(ev_in_payload)
);

// File: tb/sim_cfg_stream_packer.sv
module sim_cfg_stream_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_nopkt = 1'b0;
  logic desc_valid = 1'b0, desc_final = 1'b0;
  logic [2:0] desc_type = '0;
  logic [1:0] desc_op = '0;
  logic [13:0] desc_addr = '0;
  logic [26:0] desc_len = '0;
  logic pay_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] pay_data = '0;
  logic desc_ready, pay_ready, out_valid, out_last;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  cfg_stream_packer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_nopkt(start_nopkt),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_type(desc_type),
    .desc_op(desc_op), .desc_addr(desc_addr), .desc_len(desc_len),
    .desc_final(desc_final), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  // packet vectors: {type, opcode, address, length, final}
  localparam int NTBL = 7;
  localparam logic [46:0] TBL [0:NTBL-1] = '{
    {3'd1, 2'd2, 14'h0123, 27'h0000802, 1'b0},
    {3'd2, 2'd1, 14'h3FFF, 27'h0000004, 1'b0},
    {3'd1, 2'd0, 14'h2AAA, 27'h0000000, 1'b0},
    {3'd0, 2'd3, 14'h1111, 27'h0000005, 1'b0},
    {3'd6, 2'd1, 14'h0005, 27'h0000003, 1'b0},
    {3'd2, 2'd2, 14'h0000, 27'h0000002, 1'b1},
    {3'd1, 2'd3, 14'h0FF0, 27'h0000000, 1'b1}
  };
  localparam logic [31:0] SYNC [0:5] = '{32'hFFFFFFFF, 32'h000000BB,
    32'h11220044, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hAA995566};

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] ew [0:63];
  logic        el [0:63];
  logic        epe [0:63];
  string       etag [0:63];
  int          n_exp;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bench_hdr(input logic [46:0] v, output int n);
    logic [31:0] t, o, a, l;
    t = 32'(v[46:44]); o = 32'(v[43:42]); a = 32'(v[41:28]); l = 32'(v[27:1]);
    if (t == 1) begin
      n = int'(l % 2048);
      return t * (1 << 29) + o * (1 << 27) + a * (1 << 13) + (l % 2048);
    end else if (t == 2) begin
      n = int'(l);
      return t * (1 << 29) + o * (1 << 27) + l;
    end
    n = 0;
    return t * (1 << 29);
  endfunction

  task automatic run_stream(input int first, input int cnt, input bit nopkt);
    int optr, pi, nw;
    logic [31:0] held;
    bit held_v;
    n_exp = 0;
    for (int k = 0; k < 6; k++) begin
      ew[n_exp] = SYNC[k]; el[n_exp] = nopkt && k == 5; epe[n_exp] = 0;
      etag[n_exp] = nopkt ? "R10 preamble" : "R1 preamble"; n_exp++;
    end
    if (!nopkt) for (int p = first; p < first + cnt; p++) begin
      ew[n_exp] = bench_hdr(TBL[p], nw);
      el[n_exp] = TBL[p][0] && nw == 0; epe[n_exp] = (nw == 0);
      etag[n_exp] = (TBL[p][46:44] == 1) ? "R3 header" :
                    (TBL[p][46:44] == 2) ? "R4 header" :
                    (nw == 0 && TBL[p][46:44] == 1) ? "R6 header" : "R5 header";
      if (TBL[p][46:44] != 1 && TBL[p][46:44] != 2) etag[n_exp] = "R5 header";
      else if (nw == 0) etag[n_exp] = "R6 header";
      n_exp++;
      for (int w = 0; w < nw; w++) begin
        ew[n_exp] = 32'hC0DE0000 + 32'(p * 256 + w);
        el[n_exp] = TBL[p][0] && w == nw - 1; epe[n_exp] = (w == nw - 1);
        etag[n_exp] = "R7 payload"; n_exp++;
      end
    end
    @(negedge clk); out_ready = 0; start = 1; start_nopkt = nopkt;
    @(negedge clk); start = 0; start_nopkt = 0;
    optr = 0; pi = first; held_v = 0; held = '0;
    while (optr < n_exp && cyc < 5000) begin
      @(negedge clk); cyc++;
      out_ready = (cyc % 4) != 2;
      desc_valid = !nopkt && pi < first + cnt;
      {desc_type, desc_op, desc_addr, desc_len, desc_final} = TBL[pi < NTBL ? pi : 0];
      pay_valid = (cyc % 5) != 3;
      pay_data = ew[optr];
      #1;
      if (held_v && out_valid) check("R8 held word", out_data, held);
      held_v = 0;
      if (out_valid && !out_ready) begin held_v = 1; held = out_data; end
      if (out_valid && out_ready) begin
        check(etag[optr], out_data, ew[optr]);
        check("R9 last flag", 32'(out_last), 32'(el[optr]));
        if (epe[optr]) pi++;
        optr++;
      end
    end
    if (cyc >= 5000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", optr, n_exp);
    end
    desc_valid = 0;
    repeat (4) @(negedge clk);
    #1;
    check(nopkt ? "R10 idle valid" : "R9 idle valid", 32'(out_valid), 0);
    desc_valid = 1; #1;
    check(nopkt ? "R10 idle ready" : "R9 idle ready", 32'(desc_ready), 0);
    desc_valid = 0;
  endtask

  initial begin
    out_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset out_valid", 32'(out_valid), 0);
    check("R11 reset desc_ready", 32'(desc_ready), 0);
    check("R11 reset pay_ready", 32'(pay_ready), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check("R11 idle out_valid", 32'(out_valid), 0);
    run_stream(0, 6, 1'b0);
    run_stream(6, 1, 1'b0);
    run_stream(0, 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule